// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus (a clock line and an open-drain data line, standard-mode rates). It holds a small bank of 8-bit configuration registers for a clock generator. The rest of the chip reads that bank in parallel at all times. Both bus lines are oversampled by a fast system clock, synchronised, and turned into edge and START/STOP events. All protocol work happens in the system clock domain.

The block has no register addressing. A write begins with the device address and the write bit. The master then sends two preamble bytes, a command and a count. The slave acknowledges both and throws them away. Every byte after that lands in the next register, starting from register 0. A read begins with the device address and the read bit. The slave answers with the number of registers, then sends the registers from the lowest upward until the master stops acknowledging. A STOP or a repeated START aborts any byte that is only partly received. After either one, the slave waits for its address again.

Top module: `cfg_serial_slave`

## Requirements
- R1: The slave acknowledges the 7-bit address 0x69 followed by the direction bit (0 = write, first byte 0xD2; 1 = read, first byte 0xD3) by pulling SDA low during the ninth clock. For any other address it leaves SDA released through that ninth clock and through the rest of the transfer.
- R2: In a write, the first two bytes after the address are acknowledged and leave every register unchanged.
- R3: In a write, data byte k (k = 0 up to NREG-1, counted after the two preamble bytes) is acknowledged and stored in register k. Register k appears on `cfg_regs[8k+7:8k]`, and bytes arrive MSB first.
- R4: Data bytes past register NREG-1 are acknowledged and discarded.
- R5: A STOP or repeated START part-way through a byte discards that byte. Registers already written keep their new values, and the registers not yet reached keep their old values.
- R6: In a read, the slave sends the value NREG (6 by default) first, then registers 0, 1, and so on, MSB first. It sends 0xFF for any byte past the last register.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing until the next START.
- R8: After reset, register 0 is 0x00, each other register takes its value from the `RESET_VALUE` parameter (0xA5 by default), and SDA is released.
- R9: After a STOP, the slave releases SDA on the next system clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the pad, asynchronous |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release it |
| cfg_regs | output | NREG*8 | Register bank; register k is at bits 8k+7:8k |

## Verification
The assertions assume a bus master that changes SDA only while SCL is low, except to create START and STOP. They also assume that every SCL level lasts several system clocks longer than the synchroniser delay, so the slave's data changes settle before the next rising SCL edge. The bench master holds each quarter of a bit period for six system clocks and changes data only in the low phase. It never issues START or STOP while the slave is driving the line, so it stays inside those assumptions. Random transfer lengths and register values are mixed with directed aborts, foreign addresses and over-long reads and writes.

// File: rtl/cfgs_pkg.sv
// Shared definitions for the two-wire configuration slave.
// Assumes: data bytes are eight bits wide, transferred MSB first.
package cfgs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for START
        ST_RX,      // shifting in address or write data
        ST_RX_ACK,  // slave drives acknowledge
        ST_TX,      // shifting out read data
        ST_TX_ACK   // master acknowledge slot
    } cfgs_state_t;

endpackage

// File: rtl/cfgs_line_sync.sv
// Brings SCL and SDA into the system clock domain and derives bus events.
// Assumes: both lines idle high; clk is many times faster than SCL.
module cfgs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Metastability chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Event decode from the current and previous synchronised samples.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        bus_start = scl_s & scl_d & sda_d & ~sda_s;
        bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/cfgs_regbank.sv
// Configuration register bank with one write port and a flat parallel view.
// Assumes: at most one write per cycle; wr_idx is in range whenever wr_en is high.
module cfgs_regbank #(
    parameter int                      NREG        = 6,
    parameter logic [NREG*8-1:0]       RESET_VALUE = '0,
    localparam int                     IDXW        = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDXW-1:0]     wr_idx,
    input  logic [7:0]          wr_data,
    output logic [NREG*8-1:0]   regs_flat
);

    logic [7:0] bank [NREG];

    // Register storage: reset to parameter values, load on indexed write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                bank[i] <= RESET_VALUE[i*8 +: 8];
            else if (wr_en && wr_idx == IDXW'(i))
                bank[i] <= wr_data;
        end
    end

    // Flatten the bank onto the parallel output.
    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*8 +: 8] = bank[g];
    end

    // R5: without a write strobe the bank keeps its contents.
    p_hold_without_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));

    // R4: writes only ever target an existing register.
    p_index_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NREG));

endmodule

// File: rtl/cfgs_proto.sv
// Byte-level protocol engine: address match, preamble skip, sequential
// register write, count-prefixed sequential read, acknowledge handling.
// Assumes: events come from cfgs_line_sync; master changes SDA with SCL low.
module cfgs_proto
    import cfgs_pkg::*;
#(
    parameter int          NREG     = 6,
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    localparam int         IDXW     = $clog2(NREG),
    localparam int         BNW      = $clog2(NREG + 2) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [NREG*8-1:0] regs_flat,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [IDXW-1:0]   wr_idx,
    output logic [7:0]        wr_data
);

    cfgs_state_t       state;
    logic [3:0]        bitcnt;
    logic [7:0]        rx_sh;
    logic [7:0]        tx_sh;
    logic [BNW-1:0]    byte_no;
    logic [BNW-1:0]    byte_inc;
    logic              addr_ph;
    logic              rd_mode;
    logic [7:0]        tx_now;
    logic [7:0]        tx_succ;

    // Read-stream value for a byte position: count, registers, then filler.
    function automatic logic [7:0] tx_value(input logic [BNW-1:0] idx,
                                            input logic [NREG*8-1:0] rf);
        if (idx == '0)
            return 8'(NREG);
        else if (int'(idx) <= NREG)
            return rf[(int'(idx) - 1) * 8 +: 8];
        else
            return 8'hFF;
    endfunction

    // Next byte position (saturating) and the read bytes for both positions.
    always_comb begin
        byte_inc = (byte_no == '1) ? byte_no : byte_no + 1'b1;
        tx_now   = tx_value(byte_no, regs_flat);
        tx_succ  = tx_value(byte_inc, regs_flat);
    end

    // Protocol sequencer driven by SCL edges and START/STOP events.
    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (!rst_n) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
            bitcnt  <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            byte_no <= '0;
            addr_ph <= 1'b0;
            rd_mode <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else if (bus_start) begin
            state   <= ST_RX;
            sda_oe  <= 1'b0;
            bitcnt  <= '0;
            byte_no <= '0;
            addr_ph <= 1'b1;
            rd_mode <= 1'b0;
        end else if (bus_stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        rx_sh  <= {rx_sh[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        if (addr_ph) begin
                            if (rx_sh[7:1] == DEV_ADDR) begin
                                sda_oe  <= 1'b1;
                                rd_mode <= rx_sh[0];
                                state   <= ST_RX_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            sda_oe  <= 1'b1;
                            state   <= ST_RX_ACK;
                            byte_no <= byte_inc;
                            if (byte_no >= BNW'(2) && byte_no < BNW'(NREG + 2)) begin
                                wr_en   <= 1'b1;
                                wr_idx  <= IDXW'(byte_no - BNW'(2));
                                wr_data <= rx_sh;
                            end
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        bitcnt  <= '0;
                        addr_ph <= 1'b0;
                        if (rd_mode) begin
                            tx_sh  <= tx_now;
                            sda_oe <= ~tx_now[7];
                            state  <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            sda_oe <= ~tx_sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise && sda_s) begin
                        state <= ST_IDLE;
                    end else if (scl_fall) begin
                        bitcnt  <= '0;
                        byte_no <= byte_inc;
                        tx_sh   <= tx_succ;
                        sda_oe  <= ~tx_succ[7];
                        state   <= ST_TX;
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    // R9: a STOP releases the data line on the following cycle.
    p_release_on_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe);

    // R7: an idle slave never pulls the data line.
    p_quiet_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R1: the slave only starts pulling SDA while SCL is low.
    p_drive_low_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R3: register writes only come out of a completed, acknowledged byte.
    p_write_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_RX_ACK) && !rd_mode);

endmodule

// File: rtl/cfg_serial_slave.sv
// Top of the two-wire configuration slave: synchroniser, protocol engine
// and register bank. SDA is open-drain: sda_oe high pulls the line low.
// Assumes: clk oversamples SCL by well over the synchroniser depth.
module cfg_serial_slave #(
    parameter int                NREG        = 6,
    parameter logic [6:0]        DEV_ADDR    = 7'h69,
    parameter logic [NREG*8-1:0] RESET_VALUE = {{(NREG-1){8'hA5}}, 8'h00},
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_regs
);

    localparam int IDXW = $clog2(NREG);

    logic            scl_s;
    logic            sda_s;
    logic            scl_rise;
    logic            scl_fall;
    logic            bus_start;
    logic            bus_stop;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [7:0]      wr_data;

    cfgs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    cfgs_proto #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .regs_flat (cfg_regs),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    cfgs_regbank #(.NREG(NREG), .RESET_VALUE(RESET_VALUE)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_flat (cfg_regs)
    );

endmodule

// File: tb/sim_cfg_serial_slave.sv
// Bench: a behavioural bus master with directed and seeded random transfers,
// checked against a register model kept in the bench.
module sim_cfg_serial_slave;

    localparam int NREG = 6;
    localparam int Q    = 6;   // system clocks per quarter bit period
    localparam logic [NREG*8-1:0] RV = {{(NREG-1){8'hA5}}, 8'h00};

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl   = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] cfg_regs;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    logic [7:0] model [NREG];
    logic [7:0] wbuf  [10];

    assign sda_line = sda_oe ? 1'b0 : sda_m;

    always #2 clk = ~clk;

    cfg_serial_slave u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg_regs)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl   = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl   = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl   = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wq(Q);
        scl   = 1'b1; wq(2*Q);
        scl   = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wq(Q);
        scl   = 1'b1; wq(Q);
        ack   = !sda_line; wq(Q);
        scl   = 1'b0; wq(Q);
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wq(Q); scl = 1'b1;
            wq(Q); b = {b[6:0], sda_line};
            wq(Q); scl = 1'b0;
            wq(Q);
        end
        sda_m = mack ? 1'b0 : 1'b1; wq(Q);
        scl   = 1'b1; wq(2*Q);
        scl   = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    // Address, two preamble bytes, n data bytes from wbuf, then STOP.
    task automatic do_write(input int n);
        bit a;
        bus_start();
        send_byte(8'hD2, a);           chk(a, "R1 write address ack", a, 1);
        send_byte(8'($urandom), a);    chk(a, "R2 command byte ack", a, 1);
        send_byte(8'($urandom), a);    chk(a, "R2 count byte ack", a, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a);
            chk(a, (k < NREG) ? "R3 data byte ack" : "R4 extra byte ack", a, 1);
            if (k < NREG) model[k] = wbuf[k];
        end
        bus_stop();
        wq(2);
        chk(!sda_oe, "R9 released after stop", sda_oe, 0);
        chk(cfg_regs == model_flat(), (n == 0) ? "R2 preamble ignored" : "R3 R4 register bank",
            cfg_regs, model_flat());
    endtask

    // Read: count byte, then nrd bytes; the last one is not acknowledged.
    task automatic do_read(input int nrd);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, a);           chk(a, "R1 read address ack", a, 1);
        get_byte(1'b1, b);             chk(b == 8'(NREG), "R6 count byte", b, NREG);
        for (int k = 0; k < nrd; k++) begin
            get_byte(k < nrd - 1, b);
            chk(b == ((k < NREG) ? model[k] : 8'hFF), "R6 read data", b,
                (k < NREG) ? model[k] : 8'hFF);
        end
        wq(Q);
        chk(sda_line == 1'b1, "R7 released after nack", sda_line, 1);
        put_bit(1'b1);
        chk(sda_line == 1'b1, "R7 silent until start", sda_line, 1);
        bus_stop();
        wq(2);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        void'($urandom(32'h5EED_0C1C));
        for (int i = 0; i < NREG; i++) model[i] = RV[i*8 +: 8];
        wq(5);
        rst_n = 1'b1;
        wq(3);

        // R8: reset state
        chk(cfg_regs == RV, "R8 reset values", cfg_regs, RV);
        chk(cfg_regs[7:0] == 8'h00, "R8 register 0 zero", cfg_regs[7:0], 0);
        chk(!sda_oe, "R8 line released", sda_oe, 0);

        // R6: read defaults including a byte past the last register
        do_read(NREG + 1);

        // R2: preamble only, no data
        do_write(0);

        // R3/R4: full write plus two extra bytes
        for (int k = 0; k < 8; k++) wbuf[k] = 8'(8'h11 * (k + 1));
        do_write(8);
        do_read(NREG);

        // R1: foreign addresses are not acknowledged
        begin
            logic [7:0] bad [3] = '{8'hD0, 8'hA4, 8'hD1};
            for (int j = 0; j < 3; j++) begin
                bus_start();
                send_byte(bad[j], a);
                chk(!a, "R1 foreign address nack", a, 0);
                send_byte(8'h00, a);
                chk(!a, "R1 no ack after foreign address", a, 0);
                bus_stop();
                wq(2);
                chk(cfg_regs == model_flat(), "R1 foreign address no write",
                    cfg_regs, model_flat());
            end
        end

        // R5: STOP after a partial byte
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h3C, a); model[0] = 8'h3C;
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        wq(2);
        chk(cfg_regs == model_flat(), "R5 stop mid byte", cfg_regs, model_flat());

        // R5: repeated START after a partial byte, then a new write
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h5B, a); send_byte(8'hC6, a);
        model[0] = 8'h5B; model[1] = 8'hC6;
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        send_byte(8'hD2, a); chk(a, "R5 address after repeated start", a, 1);
        send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h99, a); model[0] = 8'h99;
        bus_stop();
        wq(2);
        chk(cfg_regs == model_flat(), "R5 repeated start", cfg_regs, model_flat());
        do_read(NREG);

        // Seeded random write lengths, data and read lengths
        for (int it = 0; it < 14; it++) begin
            int n;
            n = $urandom_range(0, 8);
            for (int k = 0; k < 10; k++) wbuf[k] = 8'($urandom);
            do_write(n);
            do_read($urandom_range(1, NREG + 1));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule